// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device out of power-up when software asks it to. Software writes a 3-bit command field through a simple register port. Writing code 001 while the field reads 000 starts the sequence. The block first issues a Precharge All. It then issues a fixed burst of Auto Refresh commands, eight by default. It finishes with a Mode Register Set whose address-bus value comes from a configuration input. Each command is followed by a programmable number of NOP cycles, which cover the device's tRP, tRC and tMRD timing rules.

A stall output stays high for the whole run, so the host processor neither fetches nor executes while the memory is unusable. When the last wait has elapsed, the block clears the command field back to 000 without any software write. Software can poll the field until it reads 000. Clock enable and both byte masks stay high throughout. Normal reads and writes, periodic refresh and the data bus are handled elsewhere.

Top module: `sdram_init_seq`

## Requirements
- R1: When the command field reads 000 and a write of 001 is presented, the field reads back 001 from the next cycle on.
- R2: The command order is one Precharge All, then exactly REFRESH_COUNT (8) Auto Refresh commands, then one Mode Register Set. The pins {cs_n, ras_n, cas_n, we_n} encode these commands as follows: Precharge 0010, Auto Refresh 0001, Mode Register Set 0000, and NOP 0111.
- R3: Each command lasts one cycle. It is followed by exactly T_RP NOP cycles after the precharge, T_RC NOP cycles after each refresh, and T_MRD NOP cycles after the mode register set. The precharge is issued in the cycle after the field becomes 001.
- R4: The stall output is high from the first cycle in which the field reads 001 through the last wait cycle. No command other than NOP appears while stall is low.
- R5: At the end of the last wait after the Mode Register Set, the field returns to 000 by itself, and stall falls in that same cycle.
- R6: During Precharge All the address bus carries 16'h0400, that is, bit 10 high and all other bits low.
- R7: During Mode Register Set the address bus equals the mode_word input.
- R8: Clock enable and both byte masks (upper and lower) are driven high at all times.
- R9: While the field reads 000, a write of any code other than 001 leaves it at 000. While a sequence runs, every write is ignored and the sequence completes unchanged.
- R10: After reset the field reads 000, stall is low, the pins show NOP, and the address bus is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the command field |
| reg_wr_data | input | 3 | Value written to the command field |
| reg_rd_data | output | 3 | Current value of the command field |
| mode_word | input | 16 | Value placed on the address bus during Mode Register Set |
| stall | output | 1 | High while the sequence runs; halts the host |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_dqm_u | output | 1 | Upper byte mask |
| sd_dqm_l | output | 1 | Lower byte mask |
| sd_addr | output | 16 | SDRAM address bus |

## Verification
The assertions assume that every wait parameter is at least one, so that two commands never stand in adjacent cycles. They also assume that mode_word is held steady while a Mode Register Set is on the pins. The bench overrides the waits with small non-zero values and changes mode_word only between runs. Its write strobes last a single cycle, aligned to the falling edge. This keeps writes issued during a run in step with the command stream that the bench predicts for that cycle.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    localparam int FIELD_W = 3;
    localparam logic [FIELD_W-1:0] FIELD_IDLE = 3'b000;
    localparam logic [FIELD_W-1:0] FIELD_INIT = 3'b001;

    localparam int ADDR_W = 16;
    localparam int PRE_ALL_BIT = 10;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001,
        CMD_MRS = 4'b0000
    } sd_cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_PRE_WAIT,
        S_REF,
        S_REF_WAIT,
        S_MRS,
        S_MRS_WAIT
    } seq_state_e;

endpackage

// File: rtl/sdinit_cmd_reg.sv
module sdinit_cmd_reg
    import sdinit_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wr_data,
    input  logic               done,
    output logic [FIELD_W-1:0] field
);

    typedef struct packed {
        logic [FIELD_W-1:0] field;
    } reg_s;

    reg_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (done) begin
            r_d.field = FIELD_IDLE;
        end else if (wr_en && (r_q.field == FIELD_IDLE) && (wr_data == FIELD_INIT)) begin
            r_d.field = FIELD_INIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{field: FIELD_IDLE};
        end else begin
            r_q <= r_d;
        end
    end

    assign field = r_q.field;

endmodule

// File: rtl/sdinit_wait_timer.sv
module sdinit_wait_timer #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             expired
);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } tmr_s;

    tmr_s t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (load) begin
            t_d.cnt = load_val;
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '{cnt: '0};
        end else begin
            t_q <= t_d;
        end
    end

    assign expired = (t_q.cnt == '0);

endmodule

// File: rtl/sdinit_seq_fsm.sv
module sdinit_seq_fsm
    import sdinit_pkg::*;
#(
    parameter int REFRESH_COUNT = 8,
    parameter int T_RP          = 3,
    parameter int T_RC          = 8,
    parameter int T_MRD         = 2,
    parameter int TW            = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          timer_expired,
    output logic          timer_load,
    output logic [TW-1:0] timer_val,
    output sd_cmd_e       cmd,
    output logic          done
);

    localparam int RCW = $clog2(REFRESH_COUNT + 1);
    localparam logic [RCW-1:0] REF_LAST = RCW'(REFRESH_COUNT);

    typedef struct packed {
        seq_state_e     state;
        logic [RCW-1:0] ref_cnt;
    } fsm_s;

    fsm_s f_d, f_q;

    always_comb begin
        f_d        = f_q;
        timer_load = 1'b0;
        timer_val  = '0;
        cmd        = CMD_NOP;
        done       = 1'b0;
        unique case (f_q.state)
            S_IDLE: begin
                f_d.ref_cnt = '0;
                if (start) f_d.state = S_PRE;
            end
            S_PRE: begin
                cmd        = CMD_PRE;
                timer_load = 1'b1;
                timer_val  = TW'(T_RP - 1);
                f_d.state  = S_PRE_WAIT;
            end
            S_PRE_WAIT: begin
                if (timer_expired) f_d.state = S_REF;
            end
            S_REF: begin
                cmd         = CMD_REF;
                timer_load  = 1'b1;
                timer_val   = TW'(T_RC - 1);
                f_d.ref_cnt = f_q.ref_cnt + 1'b1;
                f_d.state   = S_REF_WAIT;
            end
            S_REF_WAIT: begin
                if (timer_expired) begin
                    if (f_q.ref_cnt == REF_LAST) begin
                        f_d.state   = S_MRS;
                        f_d.ref_cnt = '0;
                    end else begin
                        f_d.state = S_REF;
                    end
                end
            end
            S_MRS: begin
                cmd        = CMD_MRS;
                timer_load = 1'b1;
                timer_val  = TW'(T_MRD - 1);
                f_d.state  = S_MRS_WAIT;
            end
            S_MRS_WAIT: begin
                if (timer_expired) begin
                    done      = 1'b1;
                    f_d.state = S_IDLE;
                end
            end
            default: f_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{state: S_IDLE, ref_cnt: '0};
        end else begin
            f_q <= f_d;
        end
    end

endmodule

// File: rtl/sdinit_pin_drv.sv
module sdinit_pin_drv
    import sdinit_pkg::*;
(
    input  sd_cmd_e           cmd,
    input  logic [ADDR_W-1:0] mode_word,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              dqm_u,
    output logic              dqm_l,
    output logic [ADDR_W-1:0] addr
);

    always_comb begin
        {cs_n, ras_n, cas_n, we_n} = cmd;
        addr = '0;
        unique case (cmd)
            CMD_PRE: addr[PRE_ALL_BIT] = 1'b1;
            CMD_MRS: addr = mode_word;
            default: addr = '0;
        endcase
    end

    assign cke   = 1'b1;
    assign dqm_u = 1'b1;
    assign dqm_l = 1'b1;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdinit_pkg::*;
#(
    parameter int REFRESH_COUNT = 8,
    parameter int T_RP          = 3,
    parameter int T_RC          = 8,
    parameter int T_MRD         = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [2:0]  reg_wr_data,
    output logic [2:0]  reg_rd_data,
    input  logic [15:0] mode_word,
    output logic        stall,
    output logic        sd_cke,
    output logic        sd_cs_n,
    output logic        sd_ras_n,
    output logic        sd_cas_n,
    output logic        sd_we_n,
    output logic        sd_dqm_u,
    output logic        sd_dqm_l,
    output logic [15:0] sd_addr
);

    localparam int T_MAX_A = (T_RP > T_RC) ? T_RP : T_RC;
    localparam int T_MAX   = (T_MAX_A > T_MRD) ? T_MAX_A : T_MRD;
    localparam int TW      = $clog2(T_MAX + 1);

    logic [FIELD_W-1:0] field;
    logic               done;
    logic               timer_load;
    logic [TW-1:0]      timer_val;
    logic               timer_expired;
    sd_cmd_e            cmd;

    sdinit_cmd_reg u_cmd_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .done    (done),
        .field   (field)
    );

    sdinit_seq_fsm #(
        .REFRESH_COUNT (REFRESH_COUNT),
        .T_RP          (T_RP),
        .T_RC          (T_RC),
        .T_MRD         (T_MRD),
        .TW            (TW)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (field == FIELD_INIT),
        .timer_expired (timer_expired),
        .timer_load    (timer_load),
        .timer_val     (timer_val),
        .cmd           (cmd),
        .done          (done)
    );

    sdinit_wait_timer #(.WIDTH(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (timer_expired)
    );

    sdinit_pin_drv u_pins (
        .cmd       (cmd),
        .mode_word (mode_word),
        .cke       (sd_cke),
        .cs_n      (sd_cs_n),
        .ras_n     (sd_ras_n),
        .cas_n     (sd_cas_n),
        .we_n      (sd_we_n),
        .dqm_u     (sd_dqm_u),
        .dqm_l     (sd_dqm_l),
        .addr      (sd_addr)
    );

    assign reg_rd_data = field;
    assign stall       = (field != FIELD_IDLE);

endmodule

// File: rtl/sdinit_checker.sv
module sdinit_checker #(
    parameter int REFRESH_COUNT = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic [2:0]  reg_wr_data,
    input logic [2:0]  reg_rd_data,
    input logic [15:0] mode_word,
    input logic        stall,
    input logic        sd_cke,
    input logic        sd_cs_n,
    input logic        sd_ras_n,
    input logic        sd_cas_n,
    input logic        sd_we_n,
    input logic        sd_dqm_u,
    input logic        sd_dqm_l,
    input logic [15:0] sd_addr
);

    localparam int CW = $clog2(REFRESH_COUNT + 2);

    logic [3:0] pins;
    assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    logic [CW-1:0] ref_seen_q;
    logic          mrs_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_seen_q <= '0;
            mrs_seen_q <= 1'b0;
        end else begin
            if (pins == 4'b0010) begin
                ref_seen_q <= '0;
                mrs_seen_q <= 1'b0;
            end else if (pins == 4'b0001) begin
                ref_seen_q <= ref_seen_q + 1'b1;
            end else if (pins == 4'b0000) begin
                mrs_seen_q <= 1'b1;
            end
        end
    end

    a_r1_start: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data == 3'b000 && reg_wr_en && reg_wr_data == 3'b001) |=> reg_rd_data == 3'b001);

    a_r2_ref_count: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0000) |-> ref_seen_q == CW'(REFRESH_COUNT));

    a_r3_gap_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (pins != 4'b0111) |=> pins == 4'b0111);

    a_r4_cmd_needs_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (pins != 4'b0111) |-> stall);

    a_r5_end_after_mrs: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> (mrs_seen_q && reg_rd_data == 3'b000));

    a_r6_pre_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0010) |-> sd_addr == 16'h0400);

    a_r7_mrs_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0000) |-> sd_addr == mode_word);

    a_r8_static_pins: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cke && sd_dqm_u && sd_dqm_l);

    a_r9_ignore_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data == 3'b000 && reg_wr_en && reg_wr_data != 3'b001) |=> reg_rd_data == 3'b000);

endmodule

bind sdram_init_seq sdinit_checker #(.REFRESH_COUNT(REFRESH_COUNT)) u_sdinit_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .mode_word   (mode_word),
    .stall       (stall),
    .sd_cke      (sd_cke),
    .sd_cs_n     (sd_cs_n),
    .sd_ras_n    (sd_ras_n),
    .sd_cas_n    (sd_cas_n),
    .sd_we_n     (sd_we_n),
    .sd_dqm_u    (sd_dqm_u),
    .sd_dqm_l    (sd_dqm_l),
    .sd_addr     (sd_addr)
);

// File: tb/sdram_init_seq_bench.sv
`timescale 1ns/1ps
module sdram_init_seq_bench;

    localparam int NREF  = 8;
    localparam int TRP   = 2;
    localparam int TRC   = 3;
    localparam int TMRD  = 2;
    localparam int NSAMP = 2 + TRP + NREF * (1 + TRC) + 1 + TMRD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_data = 3'b000;
    logic [2:0]  reg_rd_data;
    logic [15:0] mode_word = 16'h0000;
    logic        stall;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm_u, sd_dqm_l;
    logic [15:0] sd_addr;

    int errors = 0;
    int checks = 0;

    logic [3:0]  exp_cmd  [NSAMP];
    logic [15:0] exp_addr [NSAMP];

    always #2.5 clk = ~clk;

    sdram_init_seq #(
        .REFRESH_COUNT (NREF),
        .T_RP          (TRP),
        .T_RC          (TRC),
        .T_MRD         (TMRD)
    ) u_sdram_init_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .mode_word   (mode_word),
        .stall       (stall),
        .sd_cke      (sd_cke),
        .sd_cs_n     (sd_cs_n),
        .sd_ras_n    (sd_ras_n),
        .sd_cas_n    (sd_cas_n),
        .sd_we_n     (sd_we_n),
        .sd_dqm_u    (sd_dqm_u),
        .sd_dqm_l    (sd_dqm_l),
        .sd_addr     (sd_addr)
    );

    function automatic logic [3:0] pins();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_field(input logic [2:0] v);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_data = v;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    task automatic build_expect(input logic [15:0] mw);
        int k = 0;
        exp_cmd[k] = 4'b0111; exp_addr[k] = 16'h0; k++;
        exp_cmd[k] = 4'b0010; exp_addr[k] = 16'h0400; k++;
        for (int i = 0; i < TRP; i++) begin exp_cmd[k] = 4'b0111; exp_addr[k] = 16'h0; k++; end
        for (int r = 0; r < NREF; r++) begin
            exp_cmd[k] = 4'b0001; exp_addr[k] = 16'h0; k++;
            for (int i = 0; i < TRC; i++) begin exp_cmd[k] = 4'b0111; exp_addr[k] = 16'h0; k++; end
        end
        exp_cmd[k] = 4'b0000; exp_addr[k] = mw; k++;
        for (int i = 0; i < TMRD; i++) begin exp_cmd[k] = 4'b0111; exp_addr[k] = 16'h0; k++; end
    endtask

    // R10: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(reg_rd_data == 3'b000, "R10 field", 32'(reg_rd_data), 0);
        check(stall == 1'b0, "R10 stall", 32'(stall), 0);
        check(pins() == 4'b0111, "R10 pins NOP", 32'(pins()), 32'h7);
        check(sd_addr == 16'h0, "R10 addr", 32'(sd_addr), 0);
        check(sd_cke && sd_dqm_u && sd_dqm_l, "R8 cke/dqm after reset",
              32'({sd_cke, sd_dqm_u, sd_dqm_l}), 32'h7);
    endtask

    // R9: codes other than 001 are ignored while idle
    task automatic t_ignore_idle();
        logic [2:0] codes [6] = '{3'b010, 3'b011, 3'b100, 3'b101, 3'b111, 3'b000};
        foreach (codes[i]) begin
            write_field(codes[i]);
            check(reg_rd_data == 3'b000, "R9 idle write ignored", 32'(reg_rd_data), 0);
            @(negedge clk);
            check(stall == 1'b0 && pins() == 4'b0111, "R9 no run after ignored code",
                  32'({stall, pins()}), 32'h07);
        end
    endtask

    // R1..R8 (and R9 busy writes when poke is set)
    task automatic t_run(input logic [15:0] mw, input bit poke);
        int pre_n = 0, ref_n = 0, mrs_n = 0;
        mode_word = mw;
        build_expect(mw);
        write_field(3'b001);
        for (int s = 0; s < NSAMP; s++) begin
            check(reg_rd_data == 3'b001, "R1 field reads 001 while running", 32'(reg_rd_data), 1);
            check(stall == 1'b1, "R4 stall high during run", 32'(stall), 1);
            check(pins() == exp_cmd[s], "R2/R3 command at sample", 32'(pins()), 32'(exp_cmd[s]));
            check(sd_addr == exp_addr[s], "R6/R7 address at sample", 32'(sd_addr), 32'(exp_addr[s]));
            check(sd_cke && sd_dqm_u && sd_dqm_l, "R8 cke/dqm during run",
                  32'({sd_cke, sd_dqm_u, sd_dqm_l}), 32'h7);
            if (pins() == 4'b0010) pre_n++;
            if (pins() == 4'b0001) ref_n++;
            if (pins() == 4'b0000) mrs_n++;
            if (poke && (s == 5 || s == 17 || s == 30)) begin
                reg_wr_en   = 1'b1;
                reg_wr_data = (s == 17) ? 3'b001 : ((s == 5) ? 3'b000 : 3'b110);
            end else begin
                reg_wr_en = 1'b0;
            end
            @(negedge clk);
        end
        reg_wr_en = 1'b0;
        check(pre_n == 1 && ref_n == NREF && mrs_n == 1, "R2 command totals",
              32'((pre_n << 16) | (ref_n << 8) | mrs_n), 32'((1 << 16) | (NREF << 8) | 1));
        check(reg_rd_data == 3'b000, "R5 field self-clears", 32'(reg_rd_data), 0);
        check(stall == 1'b0, "R5 stall falls", 32'(stall), 0);
        check(pins() == 4'b0111, "R4 NOP once idle", 32'(pins()), 32'h7);
        repeat (4) @(negedge clk);
        check(reg_rd_data == 3'b000 && stall == 1'b0, "R5 stays idle",
              32'({stall, reg_rd_data}), 0);
    endtask

    initial begin
        #(5ns * 20000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_ignore_idle();
        t_run(16'h0033, 1'b0);
        t_run(16'hA5C2, 1'b1);
        t_ignore_idle();
        t_run(16'hFFFF, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule